// File: doc/BRIEF.md
# GPE register block and SCI aggregator

This block holds a small bank of general-purpose event (GPE) status and enable bytes and drives the level-sensitive system control interrupt (SCI) line. Software reaches the bank through a byte-addressed window of four bytes. An access may carry one to four bytes. A small sequencer walks through them one byte per clock, lowest byte first. Two event pulses, one for PCI slot hotplug and one for CPU hotplug, set sticky status bits. Software clears those bits by writing ones to them.

The SCI is the OR of two masked sources. The first is a fixed set of power-management event bits, taken from the status and enable words that arrive as sideband inputs. The second is bits 1 and 2 of GPE byte 0. A "timer armed" flag tells the external PM timer logic whether an overflow should be scheduled.

The access sequencer has three states. `ST_IDLE` waits for `acc_start`. `ST_SHIFT` handles one byte per clock. `ST_REPLY` pulses `acc_done` for one cycle. The transitions are:
- idle to shift, when a start is seen;
- shift to shift, while bytes remain;
- shift to reply, after the last byte;
- reply to idle, always.

Top module: `gpe_sci_hub`

## Requirements
- R1: After reset, every GPE status and enable bit is 0, `sci` and `tmr_armed` are low, and `acc_busy` is low.
- R2: The window is 4 bytes. Offsets 0 and 1 are the status bytes and offsets 2 and 3 are the enable bytes. A byte whose offset (`acc_addr` + byte index) exceeds 3 is dropped on a write and reads as 0.
- R3: An access of `acc_len`+1 bytes handles byte k of `acc_wdata`/`acc_rdata` (bits 8k+7:8k) at offset `acc_addr`+k, one byte per clock. `acc_busy` is high during the access, and `acc_done` pulses on the (`acc_len`+2)-th falling edge after the one on which the start was driven.
- R4: The enable bytes read back exactly what was last written to them.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R6: A pulse on `evt_pci` sets status byte 0 bit 1, and a pulse on `evt_cpu` sets status byte 0 bit 2. Both bits stay set until software clears them.
- R7: When a clear-by-write and an event hit the same status bit in the same clock, the bit ends up set.
- R8: `sci` is high when (`pm1_sts` & `pm1_en`) has any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC) set. No other PM1 bit contributes.
- R9: `sci` is also high when (status byte 0 & enable byte 0) has bit 1 or bit 2 set. No other GPE bit ever contributes.
- R10: `tmr_armed` is high exactly when `pm1_en` bit 0 is 1 and `pm1_sts` bit 0 is 0.
- R11: `sci` follows a register write or an event in the clock right after it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_start | input | 1 | Start an access; sampled only in idle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Byte offset of the first byte |
| acc_len | input | 2 | Byte count minus one |
| acc_wdata | input | 32 | Write bytes, little-endian |
| acc_rdata | output | 32 | Read bytes, valid when `acc_done` is high |
| acc_busy | output | 1 | Access in progress |
| acc_done | output | 1 | One-cycle end-of-access pulse |
| pm1_sts | input | 16 | PM1 event status word |
| pm1_en | input | 16 | PM1 event enable word |
| evt_pci | input | 1 | PCI hotplug event pulse |
| evt_cpu | input | 1 | CPU hotplug event pulse |
| sci | output | 1 | System control interrupt level |
| tmr_armed | output | 1 | Timer overflow should be scheduled |

## Verification
The bench builds the block with its default of two status bytes and two enable bytes, so the window is four bytes wide. With that setting, an access of up to four bytes that starts at offset 3 runs past the window, which exercises the drop rule. The same setting lets a single access span both the status and the enable halves. The bench drives a hotplug pulse on the same clock as the byte-0 clear, to check that the event wins. It also checks the one-clock latency from an event to `sci`.

// File: rtl/gpe_sci_pkg.sv
package gpe_sci_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_REPLY = 2'd2
    } seq_state_t;

    localparam int PM1_W        = 16;
    localparam int PM1_TMR_BIT  = 0;
    localparam int PM1_GLK_BIT  = 5;
    localparam int PM1_PWR_BIT  = 8;
    localparam int PM1_RTC_BIT  = 10;
    localparam int GPE_PCI_BIT  = 1;
    localparam int GPE_CPU_BIT  = 2;
    localparam int ACC_BYTES    = 4;
endpackage

// File: rtl/gpe_byte_seq.sv
module gpe_byte_seq
    import gpe_sci_pkg::*;
#(
    parameter int WIN   = 4,
    parameter int OFF_W = 2,
    parameter int SUM_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_start,
    input  logic                   acc_we,
    input  logic [OFF_W-1:0]       acc_addr,
    input  logic [1:0]             acc_len,
    input  logic [8*ACC_BYTES-1:0] acc_wdata,
    input  logic [7:0]             byte_rd,
    output logic [SUM_W-1:0]       byte_off,
    output logic                   byte_wr,
    output logic [7:0]             byte_wdata,
    output logic [8*ACC_BYTES-1:0] acc_rdata,
    output logic                   acc_busy,
    output logic                   acc_done
);
    seq_state_t state_q, state_d;

    logic                   we_q;
    logic [OFF_W-1:0]       base_q;
    logic [1:0]             len_q;
    logic [1:0]             idx_q;
    logic [8*ACC_BYTES-1:0] data_q;
    logic [8*ACC_BYTES-1:0] rdata_q;
    logic                   last_byte;
    logic                   in_win;

    assign byte_off  = SUM_W'(base_q) + SUM_W'(idx_q);
    assign in_win    = byte_off < SUM_W'(WIN);
    assign last_byte = (idx_q == len_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (acc_start) state_d = ST_SHIFT;
            ST_SHIFT: if (last_byte) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            base_q  <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (acc_start) begin
                    we_q    <= acc_we;
                    base_q  <= acc_addr;
                    len_q   <= acc_len;
                    idx_q   <= '0;
                    data_q  <= acc_wdata;
                    rdata_q <= '0;
                end
                ST_SHIFT: begin
                    rdata_q[{idx_q, 3'b000} +: 8] <= in_win ? byte_rd : 8'h00;
                    data_q <= data_q >> 8;
                    idx_q  <= idx_q + 2'd1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        byte_wr  = 1'b0;
        acc_busy = 1'b0;
        acc_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SHIFT: begin
                acc_busy = 1'b1;
                byte_wr  = we_q && in_win;
            end
            ST_REPLY: begin
                acc_busy = 1'b1;
                acc_done = 1'b1;
            end
            default:  ;
        endcase
    end

    assign byte_wdata = data_q[7:0];
    assign acc_rdata  = rdata_q;

    a_r3_reply_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_busy);
    a_r3_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_busy && acc_start) |=> (acc_busy && !acc_done));
endmodule

// File: rtl/gpe_regs.sv
module gpe_regs
    import gpe_sci_pkg::*;
#(
    parameter int NB    = 2,
    parameter int SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SUM_W-1:0] off,
    input  logic [7:0]       wdata,
    input  logic             evt_pci,
    input  logic             evt_cpu,
    output logic [7:0]       rd,
    output logic [7:0]       sts0,
    output logic [7:0]       en0
);
    logic [7:0] sts_q [NB];
    logic [7:0] en_q  [NB];

    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic [7:0] set_v;
        logic [7:0] clr_v;
        if (b == 0) begin : g_evt
            always_comb begin
                set_v = 8'h00;
                set_v[GPE_PCI_BIT] = evt_pci;
                set_v[GPE_CPU_BIT] = evt_cpu;
            end
        end else begin : g_noevt
            assign set_v = 8'h00;
        end
        assign clr_v = (wr && off == SUM_W'(b)) ? wdata : 8'h00;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[b] <= 8'h00;
                en_q[b]  <= 8'h00;
            end else begin
                sts_q[b] <= (sts_q[b] & ~clr_v) | set_v;
                if (wr && off == SUM_W'(NB + b)) en_q[b] <= wdata;
            end
        end
    end

    always_comb begin
        rd = 8'h00;
        for (int b = 0; b < NB; b++) begin
            if (off == SUM_W'(b))      rd = sts_q[b];
            if (off == SUM_W'(NB + b)) rd = en_q[b];
        end
    end

    assign sts0 = sts_q[0];
    assign en0  = en_q[0];

    a_r6_pci_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pci |=> sts0[GPE_PCI_BIT]);
    a_r6_cpu_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cpu |=> sts0[GPE_CPU_BIT]);
    a_r5_pci_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts0[GPE_PCI_BIT] && !(wr && off == '0 && wdata[GPE_PCI_BIT]))
        |=> sts0[GPE_PCI_BIT]);
    a_r4_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en0));
endmodule

// File: rtl/gpe_sci_merge.sv
module gpe_sci_merge
    import gpe_sci_pkg::*;
(
    input  logic [PM1_W-1:0] pm1_sts,
    input  logic [PM1_W-1:0] pm1_en,
    input  logic [7:0]       gpe_sts0,
    input  logic [7:0]       gpe_en0,
    output logic             sci,
    output logic             tmr_armed
);
    localparam logic [PM1_W-1:0] PM1_MASK =
        (PM1_W'(1) << PM1_TMR_BIT) | (PM1_W'(1) << PM1_GLK_BIT) |
        (PM1_W'(1) << PM1_PWR_BIT) | (PM1_W'(1) << PM1_RTC_BIT);
    localparam logic [7:0] GPE_MASK =
        (8'd1 << GPE_PCI_BIT) | (8'd1 << GPE_CPU_BIT);

    logic pm1_hit;
    logic gpe_hit;

    assign pm1_hit   = |(pm1_sts & pm1_en & PM1_MASK);
    assign gpe_hit   = |(gpe_sts0 & gpe_en0 & GPE_MASK);
    assign sci       = pm1_hit | gpe_hit;
    assign tmr_armed = pm1_en[PM1_TMR_BIT] & ~pm1_sts[PM1_TMR_BIT];
endmodule

// File: rtl/gpe_sci_hub.sv
module gpe_sci_hub
    import gpe_sci_pkg::*;
#(
    parameter int GPE_BYTES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_start,
    input  logic        acc_we,
    input  logic [1:0]  acc_addr,
    input  logic [1:0]  acc_len,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_busy,
    output logic        acc_done,
    input  logic [15:0] pm1_sts,
    input  logic [15:0] pm1_en,
    input  logic        evt_pci,
    input  logic        evt_cpu,
    output logic        sci,
    output logic        tmr_armed
);
    localparam int WIN   = 2 * GPE_BYTES;
    localparam int OFF_W = $clog2(WIN);
    localparam int SUM_W = OFF_W + 2;

    logic [SUM_W-1:0] byte_off;
    logic             byte_wr;
    logic [7:0]       byte_wdata;
    logic [7:0]       byte_rd;
    logic [7:0]       gpe_sts0;
    logic [7:0]       gpe_en0;

    gpe_byte_seq #(.WIN(WIN), .OFF_W(OFF_W), .SUM_W(SUM_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .acc_start(acc_start), .acc_we(acc_we),
        .acc_addr(OFF_W'(acc_addr)), .acc_len(acc_len),
        .acc_wdata(acc_wdata), .byte_rd(byte_rd),
        .byte_off(byte_off), .byte_wr(byte_wr), .byte_wdata(byte_wdata),
        .acc_rdata(acc_rdata), .acc_busy(acc_busy), .acc_done(acc_done)
    );

    gpe_regs #(.NB(GPE_BYTES), .SUM_W(SUM_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(byte_wr), .off(byte_off), .wdata(byte_wdata),
        .evt_pci(evt_pci), .evt_cpu(evt_cpu),
        .rd(byte_rd), .sts0(gpe_sts0), .en0(gpe_en0)
    );

    gpe_sci_merge u_merge (
        .pm1_sts(pm1_sts), .pm1_en(pm1_en),
        .gpe_sts0(gpe_sts0), .gpe_en0(gpe_en0),
        .sci(sci), .tmr_armed(tmr_armed)
    );

    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((pm1_sts & pm1_en) == '0 && gpe_en0 == 8'h00) |-> !sci);
    a_r10_timer_status_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pm1_sts[PM1_TMR_BIT] |-> !tmr_armed);
    a_r11_event_raises_sci: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pci && gpe_en0[GPE_PCI_BIT]) |=> sci);
endmodule

// File: tb/gpe_sci_hub_test.sv
module gpe_sci_hub_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_start = 1'b0, acc_we = 1'b0;
    logic [1:0]  acc_addr = '0, acc_len = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_busy, acc_done;
    logic [15:0] pm1_sts = '0, pm1_en = '0;
    logic        evt_pci = 1'b0, evt_cpu = 1'b0;
    logic        sci, tmr_armed;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpe_sci_hub uut (
        .clk(clk), .rst_n(rst_n),
        .acc_start(acc_start), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_len(acc_len), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_busy(acc_busy), .acc_done(acc_done),
        .pm1_sts(pm1_sts), .pm1_en(pm1_en),
        .evt_pci(evt_pci), .evt_cpu(evt_cpu),
        .sci(sci), .tmr_armed(tmr_armed)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access; R3 timing of acc_done is checked on every call
    task automatic access(input logic we, input logic [1:0] addr, input logic [1:0] len,
                          input logic [31:0] wd, input logic pci_in_byte0,
                          output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        acc_start = 1'b1; acc_we = we; acc_addr = addr; acc_len = len; acc_wdata = wd;
        @(negedge clk);
        acc_start = 1'b0;
        n = 1;
        check("R3 busy during access", 32'(acc_busy), 32'd1);
        if (pci_in_byte0) evt_pci = 1'b1;
        while (!acc_done && n < 20) begin
            @(negedge clk);
            evt_pci = 1'b0;
            n++;
        end
        check("R3 done cycle", n, 32'(len) + 32'd2);
        rd = acc_rdata;
        @(negedge clk);
        check("R3 idle after done", 32'(acc_busy), 32'd0);
    endtask

    task automatic pulse(input logic pci, input logic cpu);
        @(negedge clk);
        evt_pci = pci; evt_cpu = cpu;
        @(negedge clk);
        evt_pci = 1'b0; evt_cpu = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 sci after reset", 32'(sci), 32'd0);
        check("R1 tmr_armed after reset", 32'(tmr_armed), 32'd0);
        check("R1 busy after reset", 32'(acc_busy), 32'd0);
        access(1'b0, 2'd0, 2'd3, 32'h0, 1'b0, r);
        check("R1 registers zero", r, 32'h0);
    endtask

    task automatic t_events_and_enable();
        logic [31:0] r;
        pulse(1'b1, 1'b0);
        access(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, r);
        check("R6 pci sets bit1", r, 32'h02);
        check("R9 sci low with enable clear", 32'(sci), 32'd0);
        access(1'b1, 2'd2, 2'd1, 32'h0000_3C06, 1'b0, r);
        check("R9 sci from enabled pci bit", 32'(sci), 32'd1);
        access(1'b0, 2'd0, 2'd3, 32'h0, 1'b0, r);
        check("R3 R4 little-endian readback", r, 32'h3C06_0002);
        access(1'b1, 2'd0, 2'd0, 32'h0000_0002, 1'b0, r);
        check("R5 sci low after clear", 32'(sci), 32'd0);
        access(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, r);
        check("R5 status cleared", r, 32'h00);
        pulse(1'b0, 1'b1);
        check("R9 sci from cpu bit", 32'(sci), 32'd1);
        access(1'b1, 2'd0, 2'd0, 32'h0000_0001, 1'b0, r);
        access(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, r);
        check("R5 writing 0 keeps bit2 (R6 sticky)", r, 32'h04);
        access(1'b1, 2'd0, 2'd0, 32'h0000_0004, 1'b0, r);
    endtask

    task automatic t_other_bits();
        logic [31:0] r;
        access(1'b1, 2'd2, 2'd1, 32'h0000_FFF9, 1'b0, r);
        pulse(1'b1, 1'b1);
        check("R9 bits 1,2 disabled give no sci", 32'(sci), 32'd0);
        access(1'b1, 2'd0, 2'd0, 32'h0000_00FF, 1'b0, r);
        access(1'b1, 2'd2, 2'd1, 32'h0000_0006, 1'b0, r);
    endtask

    task automatic t_collision();
        logic [31:0] r;
        pulse(1'b1, 1'b0);
        access(1'b1, 2'd0, 2'd0, 32'h0000_0002, 1'b1, r);
        access(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, r);
        check("R7 event beats clear", r, 32'h02);
        access(1'b1, 2'd0, 2'd0, 32'h0000_0002, 1'b0, r);
    endtask

    task automatic t_window();
        logic [31:0] r;
        access(1'b1, 2'd3, 2'd3, 32'hFFFF_FF55, 1'b0, r);
        access(1'b0, 2'd3, 2'd3, 32'h0, 1'b0, r);
        check("R2 beyond window reads zero", r, 32'h0000_0055);
        access(1'b0, 2'd0, 2'd2, 32'h0, 1'b0, r);
        check("R2 wrapped bytes not written", r, 32'h0006_0000);
        access(1'b1, 2'd3, 2'd0, 32'h0, 1'b0, r);
    endtask

    task automatic t_pm1();
        int bits[4] = '{0, 5, 8, 10};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pm1_sts = 16'(1) << bits[i]; pm1_en = 16'(1) << bits[i];
            #1 check($sformatf("R8 pm1 bit %0d raises sci", bits[i]), 32'(sci), 32'd1);
            pm1_en = 16'h0;
            #1 check($sformatf("R8 pm1 bit %0d masked", bits[i]), 32'(sci), 32'd0);
        end
        pm1_sts = 16'hFADE; pm1_en = 16'hFADE;
        #1 check("R8 unlisted pm1 bits ignored", 32'(sci), 32'd0);
        pm1_sts = '0; pm1_en = '0;
    endtask

    task automatic t_timer();
        @(negedge clk);
        pm1_en = 16'h0001; pm1_sts = 16'h0000;
        #1 check("R10 armed", 32'(tmr_armed), 32'd1);
        pm1_sts = 16'h0001;
        #1 check("R10 status blocks", 32'(tmr_armed), 32'd0);
        pm1_en = 16'h0000; pm1_sts = 16'h0000;
        #1 check("R10 enable off", 32'(tmr_armed), 32'd0);
    endtask

    task automatic t_latency();
        logic [31:0] r;
        @(negedge clk);
        evt_pci = 1'b1;
        #1 check("R11 sci not yet", 32'(sci), 32'd0);
        @(negedge clk);
        evt_pci = 1'b0;
        check("R11 sci one edge later", 32'(sci), 32'd1);
        access(1'b1, 2'd0, 2'd0, 32'h0000_0002, 1'b0, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events_and_enable();
        t_other_bits();
        t_collision();
        t_window();
        t_pm1();
        t_timer();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule